// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the front end of a configuration space that a host reaches through two byte-wide ports: an index port at offset 0 and a data port at offset 1. The space starts out sealed. It opens only after the host writes a fixed enter key to the index port twice in a row. A leave key written to the same port seals it again. The enter/leave key pair is picked by a static input. One setting gives 0x87/0xAA and the other gives 0x88/0xBB, so two such blocks on one bus can be opened separately.

While the space is open, a byte written to the index port is latched as the current register number. Reads and writes on the data port then reach that register. Two registers are global:
- 0x07 holds the logical-device number.
- 0x20 returns a fixed chip identifier.

Indices 0x30 to 0x3F form a window into a small register file. There is one bank per logical device, and the logical-device number picks the bank. Bit 0 of register 0x30 in each bank drives that device's activate output. While sealed, every read returns 0xFF, which the host takes as "nothing here", and data writes are dropped.

Bus requests arrive on a valid/ready channel. Read data leaves on a second valid/ready channel that holds one entry. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low. A read response holds `rsp_valid` and `rsp_rdata` steady until the consumer takes it.

Top module: `cfgport_top`

## Requirements
- R1: After reset the space is sealed, the index latch and the logical-device number are 0, all bank registers are 0, `dev_active` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The space opens after two index-port writes in a row that both equal the enter key. Any other index-port byte between them restarts the sequence, so one more enter key alone does not open the space.
- R3: Writing the leave key to the index port while open seals the space. The leave key is not latched as an index, and the previously latched index is kept.
- R4: While sealed, reads of either port return 0xFF, and data-port writes change no register.
- R5: With `alt_key`=0 the keys are 0x87 (enter) and 0xAA (leave). With `alt_key`=1 they are 0x88 and 0xBB, and 0x87 written twice does not open the space. While open with `alt_key`=1, 0xAA is an ordinary index.
- R6: While open, an index-port write that is not the leave key latches the byte as the index, and an index-port read returns the latched index.
- R7: Register 0x07 is read/write and holds the logical-device number that selects the bank reached through the window.
- R8: Register 0x20 reads as the parameter CHIP_ID (default 0xA3), and writes to it are ignored.
- R9: Indices 0x30 to 0x3F read and write 16 bytes in the bank of the current logical device. Banks are independent. Bit 0 of register 0x30 of bank i drives `dev_active[i]`.
- R10: With a logical-device number of NUM_LDEV (default 4) or more, window reads return 0xFF and window writes are ignored.
- R11: While open, data-port reads of any other index return 0x00, and data-port writes to such an index are ignored.
- R12: `req_ready` equals `!rsp_valid || rsp_ready`. A read response is valid on the cycle after the request is accepted and stays valid and stable until `rsp_ready` is high. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_key | input | 1 | Static select of the alternate enter/leave key pair |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request can be accepted |
| req_addr | input | 1 | 0 = index port, 1 = data port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the read response |
| rsp_rdata | output | 8 | Read response byte |
| cfg_open | output | 1 | Configuration space is open |
| dev_active | output | NUM_LDEV | Activate bit of each logical device |

## Verification
The unlock sequence is driven with a clean double key, with a stray byte between two keys, and with the other key pair's bytes under each setting of `alt_key`. These patterns separate a sequence that restarts from one that merely counts keys, and show that the key pair really follows the select. Data-port traffic is tried while sealed, at the identifier, the device number, in-range and out-of-range banks, and unmapped indices. Together they show which writes may land and where reads fall back to 0xFF or 0x00. A held response with `rsp_ready` low shows the back-pressure stalls new requests without losing data.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam logic [7:0] ENTER_STD = 8'h87;
  localparam logic [7:0] LEAVE_STD = 8'hAA;
  localparam logic [7:0] ENTER_ALT = 8'h88;
  localparam logic [7:0] LEAVE_ALT = 8'hBB;

  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;

  localparam logic [7:0] NO_DEVICE  = 8'hFF;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } keystate_e;

endpackage

// File: rtl/cfgport_keyseq.sv
module cfgport_keyseq
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_key,
  input  logic       idx_wr,
  input  logic [7:0] idx_byte,
  output logic       open,
  output logic       idx_load
);

  keystate_e  state_q, state_d;
  logic [7:0] enter_key, leave_key;

  assign enter_key = alt_key ? ENTER_ALT : ENTER_STD;
  assign leave_key = alt_key ? LEAVE_ALT : LEAVE_STD;

  always_comb begin
    state_d  = state_q;
    idx_load = 1'b0;
    unique case (state_q)
      KS_LOCKED: if (idx_wr && idx_byte == enter_key) state_d = KS_HALF;
      KS_HALF:   if (idx_wr) state_d = (idx_byte == enter_key) ? KS_OPEN : KS_LOCKED;
      KS_OPEN: begin
        if (idx_wr) begin
          if (idx_byte == leave_key) state_d = KS_LOCKED;
          else                       idx_load = 1'b1;
        end
      end
      default: state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open = (state_q == KS_OPEN);

  // R2: opening is only ever preceded by the half-open state
  a_r2_open_via_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(state_q) == KS_HALF);

  // R2: a stray byte after the first key restarts the sequence
  a_r2_stray_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_HALF && idx_wr && idx_byte != enter_key) |=> state_q == KS_LOCKED);

  // R3: leave key seals the space
  a_r3_leave_seals: assert property (@(posedge clk) disable iff (!rst_n)
    (open && idx_wr && idx_byte == leave_key) |=> !open);

endmodule

// File: rtl/cfgport_devbank.sv
module cfgport_devbank #(
  parameter int NUM_LDEV = 4,
  parameter int DEV_REGS = 16,
  localparam int OFS_W   = $clog2(DEV_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          ldn,
  input  logic [OFS_W-1:0]    offset,
  input  logic [7:0]          wdata,
  output logic                ldn_ok,
  output logic [7:0]          rdata,
  output logic [NUM_LDEV-1:0] dev_active
);

  logic [7:0] bank_rd [NUM_LDEV];

  assign ldn_ok = ({24'd0, ldn} < NUM_LDEV);

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_bank
    logic [7:0] regs_q [DEV_REGS];
    logic       we;

    assign we = wr_en && ldn_ok && ({24'd0, ldn} == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int r = 0; r < DEV_REGS; r++) regs_q[r] <= 8'h00;
      end else if (we) begin
        regs_q[offset] <= wdata;
      end
    end

    assign bank_rd[g]    = regs_q[offset];
    assign dev_active[g] = regs_q[0][0];
  end

  always_comb begin
    rdata = 8'hFF;
    for (int d = 0; d < NUM_LDEV; d++) begin
      if ({24'd0, ldn} == d) rdata = bank_rd[d];
    end
  end

  // R10: no bank changes while the device number is out of range
  a_r10_oob_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !ldn_ok |=> $stable(dev_active));

  // R9: activate outputs move only on a bank write
  a_r9_active_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dev_active));

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int         NUM_LDEV = 4,
  parameter int         DEV_REGS = 16,
  parameter logic [7:0] DEV_BASE = 8'h30,
  parameter logic [7:0] CHIP_ID  = 8'hA3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alt_key,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_addr,
  input  logic                req_write,
  input  logic [7:0]          req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [7:0]          rsp_rdata,
  output logic                cfg_open,
  output logic [NUM_LDEV-1:0] dev_active
);

  localparam int OFS_W = $clog2(DEV_REGS);

  logic       acc, idx_wr, data_wr, idx_load, open;
  logic [7:0] index_q, ldn_q, win_diff, bank_rdata, rd_val;
  logic       in_window, ldn_ok;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign idx_wr    = acc && req_write && !req_addr;
  assign data_wr   = acc && req_write && req_addr && open;

  cfgport_keyseq u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .alt_key  (alt_key),
    .idx_wr   (idx_wr),
    .idx_byte (req_wdata),
    .open     (open),
    .idx_load (idx_load)
  );

  assign cfg_open = open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else begin
      if (idx_load) index_q <= req_wdata;
      if (data_wr && index_q == IDX_LDN) ldn_q <= req_wdata;
    end
  end

  assign win_diff  = index_q - DEV_BASE;
  assign in_window = (index_q >= DEV_BASE) && ({24'd0, win_diff} < DEV_REGS);

  cfgport_devbank #(
    .NUM_LDEV (NUM_LDEV),
    .DEV_REGS (DEV_REGS)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (data_wr && in_window),
    .ldn        (ldn_q),
    .offset     (win_diff[OFS_W-1:0]),
    .wdata      (req_wdata),
    .ldn_ok     (ldn_ok),
    .rdata      (bank_rdata),
    .dev_active (dev_active)
  );

  always_comb begin
    if (!open)                    rd_val = NO_DEVICE;
    else if (!req_addr)           rd_val = index_q;
    else if (index_q == IDX_LDN)  rd_val = ldn_q;
    else if (index_q == IDX_CHIPID) rd_val = CHIP_ID;
    else if (in_window)           rd_val = ldn_ok ? bank_rdata : NO_DEVICE;
    else                          rd_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R4: sealed reads answer 0xFF
  a_r4_sealed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && !open) |=> rsp_valid && rsp_rdata == NO_DEVICE);

  // R8: identifier register
  a_r8_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr && open && index_q == IDX_CHIPID) |=> rsp_rdata == CHIP_ID);

  // R12: held response is stable
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  // R12: writes yield no response
  a_r12_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !rsp_valid);

  // R7: device number only moves on a data write
  a_r7_ldn_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(ldn_q));

endmodule

// File: tb/cfgport_top_test.sv
module cfgport_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alt_key = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_addr = 1'b0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       rsp_ready = 1'b1;
  logic       req_ready, rsp_valid, cfg_open;
  logic [7:0] rsp_rdata;
  logic [3:0] dev_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfgport_top uut (
    .clk(clk), .rst_n(rst_n), .alt_key(alt_key),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_open(cfg_open), .dev_active(dev_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = 1'b1; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 8'hXX;
  endtask

  task automatic unlock();
    bus_wr(0, 8'h87);
    bus_wr(0, 8'h87);
  endtask

  task automatic sel(input logic [7:0] idx);
    bus_wr(0, idx);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cfg_open", cfg_open, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 dev_active", dev_active, 0);
    unlock();
    bus_rd(0, d);
    chk("R1 index reset", d, 8'h00);
    sel(8'h07);
    bus_rd(1, d);
    chk("R1 ldn reset", d, 8'h00);
    bus_wr(0, 8'hAA);
  endtask

  task automatic t_sealed();
    logic [7:0] d;
    bus_rd(0, d);
    chk("R4 sealed index read", d, 8'hFF);
    bus_rd(1, d);
    chk("R4 sealed data read", d, 8'hFF);
    bus_wr(1, 8'h02);
    unlock();
    bus_rd(0, d);
    chk("R3 index kept across seal", d, 8'h07);
    bus_rd(1, d);
    chk("R4 sealed write ignored", d, 8'h00);
    bus_wr(0, 8'hAA);
  endtask

  task automatic t_sequence();
    bus_wr(0, 8'h87);
    bus_wr(0, 8'h12);
    bus_wr(0, 8'h87);
    chk("R2 stray byte restarts", cfg_open, 0);
    bus_wr(0, 8'h87);
    chk("R2 double key opens", cfg_open, 1);
    bus_wr(0, 8'hAA);
    chk("R3 leave seals", cfg_open, 0);
  endtask

  task automatic t_alt();
    logic [7:0] d;
    alt_key = 1'b1;
    unlock();
    chk("R5 std key with alt", cfg_open, 0);
    bus_wr(0, 8'h88);
    bus_wr(0, 8'h88);
    chk("R5 alt key opens", cfg_open, 1);
    bus_wr(0, 8'hAA);
    chk("R5 std leave ignored", cfg_open, 1);
    bus_rd(0, d);
    chk("R5 0xAA latched as index", d, 8'hAA);
    bus_wr(0, 8'hBB);
    chk("R5 alt leave seals", cfg_open, 0);
    alt_key = 1'b0;
  endtask

  task automatic t_index_id();
    logic [7:0] d;
    unlock();
    sel(8'h20);
    bus_rd(0, d);
    chk("R6 index readback", d, 8'h20);
    bus_rd(1, d);
    chk("R8 chip id", d, 8'hA3);
    bus_wr(1, 8'h00);
    bus_rd(1, d);
    chk("R8 id write ignored", d, 8'hA3);
  endtask

  task automatic t_banks();
    logic [7:0] d;
    sel(8'h07); bus_wr(1, 8'h02);
    bus_rd(1, d);
    chk("R7 ldn readback", d, 8'h02);
    sel(8'h30); bus_wr(1, 8'h01);
    chk("R9 activate dev2", dev_active, 4'b0100);
    sel(8'h3F); bus_wr(1, 8'hC3);
    sel(8'h07); bus_wr(1, 8'h01);
    sel(8'h30); bus_rd(1, d);
    chk("R9 bank1 activate clear", d, 8'h00);
    sel(8'h35); bus_wr(1, 8'h5A);
    bus_rd(1, d);
    chk("R9 bank1 reg 0x35", d, 8'h5A);
    sel(8'h07); bus_wr(1, 8'h02);
    sel(8'h35); bus_rd(1, d);
    chk("R9 bank2 independent", d, 8'h00);
    sel(8'h3F); bus_rd(1, d);
    chk("R9 bank2 top reg", d, 8'hC3);
  endtask

  task automatic t_oob();
    logic [7:0] d;
    sel(8'h07); bus_wr(1, 8'h09);
    sel(8'h30); bus_rd(1, d);
    chk("R10 oob read", d, 8'hFF);
    bus_wr(1, 8'h01);
    chk("R10 oob write ignored", dev_active, 4'b0100);
    sel(8'h07); bus_wr(1, 8'h02);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    sel(8'h10); bus_wr(1, 8'h77);
    bus_rd(1, d);
    chk("R11 low unmapped", d, 8'h00);
    sel(8'h40); bus_wr(1, 8'h77);
    bus_rd(1, d);
    chk("R11 past window", d, 8'h00);
  endtask

  task automatic t_backpressure();
    sel(8'h20);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 1'b1; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 response valid", rsp_valid, 1);
    chk("R12 ready low when held", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R12 held valid", rsp_valid, 1);
    chk("R12 held data", rsp_rdata, 8'hA3);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R12 popped", rsp_valid, 0);
    bus_wr(0, 8'h30);
    chk("R12 write no response", rsp_valid, 0);
    bus_wr(0, 8'hAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sealed();
    t_sequence();
    t_alt();
    t_index_id();
    t_banks();
    t_oob();
    t_unmapped();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule